// File: doc/BRIEF.md
# Four-Phase Polyphase Interpolator

This unit sits beside a processor as a custom-instruction engine. It raises the sample rate of a signed 32-bit stream by four with a 4-tap polyphase filter whose coefficients are fixed and scaled by 16384. Each call gives a 2-bit phase selector, a 32-bit operand and a one-cycle start strobe. The unit answers with one 32-bit output sample and a one-cycle done strobe. The output stays at the coefficient scale.

Software issues four calls for every input sample, one for each phase. Phases 0, 1 and 2 only read the delay line. The phase-3 call first produces its output from the current taps. It then shifts the operand into the four-entry delay line, which is held inside the unit. A single signed multiplier and one accumulator are shared across the taps. They walk the taps over four consecutive cycles under a small state machine.

Top module: `interp4_unit`

## Requirements
- R1: After a synchronous active-low reset, done_o is low and result_o is zero. All four taps are zero, so every phase returns zero until a sample has been shifted in.
- R2: The call for phase p returns tap0*c[p] + tap1*c[p+4] + tap2*c[p+8] + tap3*c[p+12]. tap0 is the newest sample. The table c, from index 0 upward, is 0, -2107, -3477, -2950, 0, 4917, 10430, 14751, 16383, 14751, 10430, 4917, 0, -2950, -3477, -2107.
- R3: Every product keeps only its low 32 bits. The sum wraps modulo 2^32, exactly as 32-bit C integer arithmetic does.
- R4: Calls with phase 0, 1 or 2 ignore the operand and leave the delay line unchanged.
- R5: A phase-3 call computes its output from the taps as they were before the call. Only then does it shift: tap3 takes tap2, tap2 takes tap1, tap1 takes tap0, and tap0 takes the operand.
- R6: Take the clock edge that samples start_i high in the idle state. done_o rises four cycles after that edge and stays high for exactly one cycle, with result_o valid. result_o then holds until the next accepted call.
- R7: start_i is ignored from the accepting edge through the done cycle. Phase and operand changes during that window affect neither the result nor the taps.
- R8: From reset, shift in sample 103 with phase 3 (that output is 0). A phase-1 call then returns -217021, and a phase-2 call returns -358131.
- R9: Reset asserted in the middle of a call aborts it. No done pulse follows, the result is zero and the taps are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Call strobe, sampled only while idle |
| phase_i | input | 2 | Phase selector of the call |
| sample_i | input | 32 | Operand; new sample for a phase-3 call |
| result_o | output | 32 | Output sample, valid while done_o is high |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
The hardest states to reach from the ports are the ones inside the four accumulate cycles. One is a second call arriving while the engine is busy; the other is reset landing halfway through a call. The bench reaches the first by holding start high through the whole call. During that time it changes the phase to 3 and the operand to a marker, then checks both the returned value and the next output, which would show any spurious shift. For the second, it pulls reset two cycles into a phase-3 call. It then checks that done never rises and that the following calls see a cleared delay line. Wrap-around is forced with full-scale positive and negative samples.

// File: rtl/interp4_pkg.sv
// Package interp4_pkg
// Shared widths, the controller state type and the constant coefficient
// table for the four-phase interpolator. Assumes 16 coefficients at a
// scale of 2^14, indexed as (tap * phases + phase).
package interp4_pkg;

    localparam int DATA_W     = 32;
    localparam int NUM_TAPS   = 4;
    localparam int NUM_PHASES = 4;
    localparam int COEF_N     = NUM_TAPS * NUM_PHASES;
    localparam int COEF_AW    = $clog2(COEF_N);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACC  = 2'd1,
        ST_DONE = 2'd2
    } state_t;

    // Returns the quantized kernel value for a coefficient index.
    function automatic logic signed [DATA_W-1:0] coef_lut(input logic [COEF_AW-1:0] idx);
        logic signed [DATA_W-1:0] v;
        case (idx)
            4'd0:  v = 0;
            4'd1:  v = -2107;
            4'd2:  v = -3477;
            4'd3:  v = -2950;
            4'd4:  v = 0;
            4'd5:  v = 4917;
            4'd6:  v = 10430;
            4'd7:  v = 14751;
            4'd8:  v = 16383;
            4'd9:  v = 14751;
            4'd10: v = 10430;
            4'd11: v = 4917;
            4'd12: v = 0;
            4'd13: v = -2950;
            4'd14: v = -3477;
            default: v = -2107;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/interp4_coef_rom.sv
// Module interp4_coef_rom
// Combinational constant lookup of one filter coefficient.
// Assumes the index is formed as {tap_index, phase}.
module interp4_coef_rom
    import interp4_pkg::*;
#(
    parameter int AW = COEF_AW,
    parameter int DW = DATA_W
) (
    input  logic [AW-1:0] idx_i,
    output logic [DW-1:0] coef_o
);

    // Table read through the package function.
    always_comb begin
        coef_o = DW'(coef_lut(COEF_AW'(idx_i)));
    end

endmodule

// File: rtl/interp4_delay_line.sv
// Module interp4_delay_line
// Holds the filter taps, shifts in a new sample on request and exposes
// one tap selected by index. Assumes shift_i lasts a single cycle.
module interp4_delay_line #(
    parameter int DW    = 32,
    parameter int TAPS  = 4,
    localparam int SELW = $clog2(TAPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_i,
    input  logic [DW-1:0]     sample_i,
    input  logic [SELW-1:0]   sel_i,
    output logic [DW-1:0]     tap_o,
    output logic [DW*TAPS-1:0] taps_flat_o
);

    logic [DW-1:0] taps [TAPS];

    genvar k;
    generate
        for (k = 0; k < TAPS; k++) begin : g_tap
            // Tap register k: cleared by reset, loaded on shift.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    taps[k] <= '0;
                end else if (shift_i) begin
                    if (k == 0) taps[k] <= sample_i;
                    else        taps[k] <= taps[(k == 0) ? 0 : k-1];
                end
            end
            assign taps_flat_o[k*DW +: DW] = taps[k];
        end
    endgenerate

    // Tap selection feeding the shared multiplier.
    always_comb begin
        tap_o = taps[sel_i];
    end

endmodule

// File: rtl/interp4_mac.sv
// Module interp4_mac
// One shared signed multiplier and a wrapping accumulator. Only the low
// DW bits of each product are kept, matching native integer arithmetic.
module interp4_mac #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          en_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    output logic [DW-1:0] acc_o
);

    logic signed [DW-1:0] a_s;
    logic signed [DW-1:0] b_s;
    logic signed [DW-1:0] prod;

    // Truncated signed product of the selected tap and coefficient.
    always_comb begin
        a_s  = a_i;
        b_s  = b_i;
        prod = a_s * b_s;
    end

    // Accumulator: cleared at call start, adds one product per step.
    always_ff @(posedge clk) begin
        if (!rst_n)      acc_o <= '0;
        else if (clr_i)  acc_o <= '0;
        else if (en_i)   acc_o <= acc_o + DW'(prod);
    end

endmodule

// File: rtl/interp4_ctrl.sv
// Module interp4_ctrl
// Call sequencer: accepts a call while idle, steps the tap index through
// every tap, raises done for one cycle and requests the delay-line shift
// on the last step of a final-phase call. Start is ignored while busy.
module interp4_ctrl
    import interp4_pkg::*;
#(
    parameter int DW     = 32,
    parameter int TAPS   = 4,
    parameter int PHASES = 4,
    localparam int TW    = $clog2(TAPS),
    localparam int PW    = $clog2(PHASES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [PW-1:0] phase_i,
    input  logic [DW-1:0] sample_i,
    output state_t        state_o,
    output logic [TW-1:0] tap_idx_o,
    output logic [PW-1:0] phase_q_o,
    output logic [DW-1:0] sample_q_o,
    output logic          acc_clr_o,
    output logic          acc_en_o,
    output logic          shift_o,
    output logic          done_o
);

    localparam logic [TW-1:0] LAST_TAP   = TW'(TAPS - 1);
    localparam logic [PW-1:0] LAST_PHASE = PW'(PHASES - 1);

    logic last_step;

    // State, tap counter and latched call arguments.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_o    <= ST_IDLE;
            tap_idx_o  <= '0;
            phase_q_o  <= '0;
            sample_q_o <= '0;
        end else begin
            case (state_o)
                ST_IDLE: begin
                    if (start_i) begin
                        state_o    <= ST_ACC;
                        tap_idx_o  <= '0;
                        phase_q_o  <= phase_i;
                        sample_q_o <= sample_i;
                    end
                end
                ST_ACC: begin
                    tap_idx_o <= tap_idx_o + 1'b1;
                    if (last_step) state_o <= ST_DONE;
                end
                default: state_o <= ST_IDLE;
            endcase
        end
    end

    // Datapath strobes decoded from the current state.
    always_comb begin
        last_step = (state_o == ST_ACC) && (tap_idx_o == LAST_TAP);
        acc_clr_o = (state_o == ST_IDLE) && start_i;
        acc_en_o  = (state_o == ST_ACC);
        shift_o   = last_step && (phase_q_o == LAST_PHASE);
        done_o    = (state_o == ST_DONE);
    end

endmodule

// File: rtl/interp4_unit.sv
// Module interp4_unit
// Top of the four-phase polyphase interpolator. One call returns one
// output sample after TAPS accumulate cycles; the final-phase call also
// shifts its operand into the delay line after its output is formed.
// Assumes TAPS and PHASES are powers of two.
module interp4_unit
    import interp4_pkg::*;
#(
    parameter int DATA_W_P   = DATA_W,
    parameter int NUM_TAPS_P = NUM_TAPS,
    parameter int NUM_PH_P   = NUM_PHASES
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic [$clog2(NUM_PH_P)-1:0] phase_i,
    input  logic [DATA_W_P-1:0]         sample_i,
    output logic [DATA_W_P-1:0]         result_o,
    output logic                        done_o
);

    localparam int TW = $clog2(NUM_TAPS_P);
    localparam int PW = $clog2(NUM_PH_P);
    localparam int CW = TW + PW;

    state_t                          state;
    logic [TW-1:0]                   tap_idx;
    logic [PW-1:0]                   phase_q;
    logic [DATA_W_P-1:0]             sample_q;
    logic                            acc_clr;
    logic                            acc_en;
    logic                            shift_en;
    logic [DATA_W_P-1:0]             tap_sel;
    logic [DATA_W_P-1:0]             coef;
    logic [DATA_W_P*NUM_TAPS_P-1:0]  taps_flat;

    interp4_ctrl #(
        .DW(DATA_W_P), .TAPS(NUM_TAPS_P), .PHASES(NUM_PH_P)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .phase_i(phase_i), .sample_i(sample_i),
        .state_o(state), .tap_idx_o(tap_idx), .phase_q_o(phase_q),
        .sample_q_o(sample_q), .acc_clr_o(acc_clr), .acc_en_o(acc_en),
        .shift_o(shift_en), .done_o(done_o)
    );

    interp4_delay_line #(
        .DW(DATA_W_P), .TAPS(NUM_TAPS_P)
    ) u_taps (
        .clk(clk), .rst_n(rst_n), .shift_i(shift_en),
        .sample_i(sample_q), .sel_i(tap_idx),
        .tap_o(tap_sel), .taps_flat_o(taps_flat)
    );

    interp4_coef_rom #(
        .AW(CW), .DW(DATA_W_P)
    ) u_rom (
        .idx_i({tap_idx, phase_q}),
        .coef_o(coef)
    );

    interp4_mac #(
        .DW(DATA_W_P)
    ) u_mac (
        .clk(clk), .rst_n(rst_n), .clr_i(acc_clr), .en_i(acc_en),
        .a_i(tap_sel), .b_i(coef), .acc_o(result_o)
    );

endmodule

// File: rtl/interp4_chk.sv
// Module interp4_chk
// Protocol and sequencing checks for interp4_unit, attached by bind.
module interp4_chk
    import interp4_pkg::*;
#(
    parameter int DW   = 32,
    parameter int TAPS = 4,
    parameter int PW   = 2,
    localparam int TW  = $clog2(TAPS)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic               done_o,
    input logic [DW-1:0]      result_o,
    input state_t             state,
    input logic [TW-1:0]      tap_idx,
    input logic [PW-1:0]      phase_q,
    input logic               shift_en,
    input logic [DW*TAPS-1:0] taps_flat
);

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(state == ST_ACC && tap_idx == TW'(TAPS - 1)));

    assert_step_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACC && tap_idx != TW'(TAPS - 1)) |=>
            (state == ST_ACC && tap_idx == $past(tap_idx) + 1'b1));

    assert_busy_phase_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(phase_q));

    assert_taps_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(taps_flat));

    assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_ACC && !(state == ST_IDLE && start_i)) |=> $stable(result_o));

    assert_shift_final_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |-> (phase_q == PW'((1 << PW) - 1)));

endmodule

bind interp4_unit interp4_chk #(
    .DW(DATA_W_P), .TAPS(NUM_TAPS_P), .PW($clog2(NUM_PH_P))
) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_o(done_o),
    .result_o(result_o), .state(state), .tap_idx(tap_idx),
    .phase_q(phase_q), .shift_en(shift_en), .taps_flat(taps_flat)
);

// File: tb/interp4_unit_bench.sv
// Directed bench for interp4_unit with a software model of the taps.
module interp4_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  phase_i = '0;
    logic [31:0] sample_i = '0;
    logic [31:0] result_o;
    logic        done_o;

    int n_checks = 0;
    int n_fails  = 0;
    int m_tap [4];
    int cf [16] = '{0, -2107, -3477, -2950, 0, 4917, 10430, 14751,
                    16383, 14751, 10430, 4917, 0, -2950, -3477, -2107};

    always #5 clk = ~clk;

    interp4_unit u_interp4_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .phase_i(phase_i),
        .sample_i(sample_i), .result_o(result_o), .done_o(done_o)
    );

    task automatic check(input int got, input int exp, input string req);
        n_checks++;
        if (got != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    // Model: output of a phase from current taps, then shift on phase 3.
    task automatic model_call(input int ph, input int smp, output int exp);
        exp = m_tap[0]*cf[ph] + m_tap[1]*cf[ph+4] + m_tap[2]*cf[ph+8] + m_tap[3]*cf[ph+12];
        if (ph == 3) begin
            m_tap[3] = m_tap[2];
            m_tap[2] = m_tap[1];
            m_tap[1] = m_tap[0];
            m_tap[0] = smp;
        end
    endtask

    // One call; jam keeps start high with phase 3 and a marker while busy.
    task automatic dut_call(input int ph, input int smp, input bit jam,
                            output int got, output int lat);
        @(negedge clk);
        start_i = 1'b1; phase_i = 2'(ph); sample_i = smp;
        @(negedge clk);
        lat = 1;
        if (jam) begin phase_i = 2'd3; sample_i = 32'h5A5A5A5A; end
        else start_i = 1'b0;
        while (!done_o && lat < 30) begin @(negedge clk); lat++; end
        got = result_o;
        start_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic call_check(input int ph, input int smp, input string req);
        int got, lat, exp;
        dut_call(ph, smp, 1'b0, got, lat);
        model_call(ph, smp, exp);
        check(got, exp, req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        foreach (m_tap[i]) m_tap[i] = 0;
    endtask

    task automatic t_reset_state();
        do_reset();
        check(int'(done_o), 0, "R1 done after reset");
        check(int'(result_o), 0, "R1 result after reset");
        for (int p = 0; p < 3; p++) call_check(p, 32'h1234, "R1 zero taps");
    endtask

    task automatic t_first_sample();
        do_reset();
        call_check(3, 103, "R8 push 103");
        call_check(1, 0, "R8 phase1");
        check(int'(result_o), -217021, "R8 phase1 literal");
        call_check(2, 0, "R8 phase2");
        check(int'(result_o), -358131, "R8 phase2 literal");
        call_check(3, 198, "R5 phase3 before shift");
        check(int'(result_o), -303850, "R5 phase3 literal");
    endtask

    task automatic t_latency();
        int got, lat, exp;
        dut_call(0, 0, 1'b0, got, lat);
        model_call(0, 0, exp);
        check(lat, 5, "R6 done latency");
        check(got, exp, "R6 result at done");
        check(int'(done_o), 0, "R6 done one cycle");
        check(int'(result_o), got, "R6 result held");
    endtask

    task automatic t_operand_ignored();
        call_check(0, 32'h7FFF0001, "R4 phase0 operand");
        call_check(1, -99999, "R4 phase1 operand");
        call_check(2, 32'h80000000, "R4 phase2 operand");
        call_check(1, 0, "R4 taps unchanged");
    endtask

    task automatic t_busy_start();
        int got, lat, exp;
        dut_call(1, 4444, 1'b1, got, lat);
        model_call(1, 4444, exp);
        check(got, exp, "R7 busy start result");
        check(lat, 5, "R7 busy start latency");
        call_check(2, 0, "R7 no spurious shift");
    endtask

    task automatic t_wrap();
        call_check(3, 32'h7FFFFFFF, "R3 push max");
        call_check(3, 32'h80000000, "R3 push min");
        call_check(3, 32'h7FFFFFFF, "R3 push max again");
        for (int p = 0; p < 4; p++) call_check(p, 32'h6ABCDEF1, "R3 wrapped sum");
    endtask

    task automatic t_stream();
        do_reset();
        for (int s = 0; s < 48; s++) begin
            int smp;
            smp = ((s % 32) >= 26) ? 0 : (int'($urandom) >>> ($urandom % 16));
            for (int p = 0; p < 3; p++) call_check(p, int'($urandom), "R2 stream phase");
            call_check(3, smp, "R5 stream phase3");
        end
    endtask

    task automatic t_reset_mid();
        call_check(3, 555, "R9 preload");
        @(negedge clk);
        start_i = 1'b1; phase_i = 2'd3; sample_i = 777;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        foreach (m_tap[i]) m_tap[i] = 0;
        for (int c = 0; c < 5; c++) begin
            check(int'(done_o), 0, "R9 no done after abort");
            @(negedge clk);
        end
        check(int'(result_o), 0, "R9 result cleared");
        call_check(3, 321, "R9 cleared taps");
        call_check(1, 0, "R9 after abort");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL R6 watchdog actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        t_reset_state();
        t_first_sample();
        t_latency();
        t_operand_ignored();
        t_busy_start();
        t_wrap();
        t_stream();
        t_reset_mid();
        summary();
        $finish;
    end

endmodule